// File: doc/BRIEF.md
# Snooping MSI Coherence Cluster

This block holds a group of private cache-line controllers that stay coherent over one shared broadcast bus using write-invalidate. Each controller keeps a small direct-mapped array of tags, one data word per line, and a three-valued line state: Invalid, Shared (clean) or Modified (dirty). A processor port on each controller takes read and write requests. Every controller watches the bus transactions of its peers and adjusts its own lines in response.

A round-robin arbiter lets one controller own the bus per cycle. Each transaction completes atomically in that cycle. A flat memory model supplies data on misses and absorbs write-backs. Two kinds of write-back exist: a dirty owner writes back when a peer reads or claims its line, and a controller writes back a dirty victim on a conflict miss. The bus signals are brought out so that the order of transactions can be observed.

Top module: `snoop_msi_cluster`

## Requirements
- R1: After reset no `cpu_done` bit is set, the bus is idle with no request pending, every line is Invalid and memory holds zero. A first read therefore goes to the bus and returns 0.
- R2: A read that misses issues a bus read (`bus_cmd` = 1) and installs the line Shared. A read that hits a Shared or Modified line uses no bus cycle. Any number of controllers may hold one line Shared at the same time.
- R3: A write to a Shared line issues an upgrade (`bus_cmd` = 3). A write to a line that is absent issues a read-exclusive (`bus_cmd` = 2). In both cases the writer ends Modified and every other copy becomes Invalid, so the next read by a former holder misses.
- R4: A write that hits a Modified line completes locally with no bus transaction.
- R5: A bus read of a line held Modified by a peer returns the owner's latest data to the requester and writes that data to memory. The owner drops to Shared, so its next write issues an upgrade.
- R6: A conflict miss that displaces a Modified line writes the old data to memory. A later read of the old address by another controller returns it.
- R7: At most one grant is issued per cycle. Directly after reset, controller 0 has the highest priority. After that, priority starts at the controller following the last one granted and wraps around.
- R8: Every read returns the most recent value written to that address by any controller, in bus order.
- R9: At most one controller holds a given line Modified. While one does, no other controller holds any valid copy of that line.
- R10: `cpu_done` pulses high for exactly one cycle per request. For a local hit it rises in the cycle after the request is accepted. For a bus request it rises in the cycle after the one in which the controller held the grant. Local hits wait while the bus is busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | N_CACHE | Per-controller request, held until its done pulse |
| cpu_we | input | N_CACHE | Per-controller write (1) or read (0) |
| cpu_addr | input | N_CACHE*ADDR_W | Per-controller word address, controller i at slice i |
| cpu_wdata | input | N_CACHE*DATA_W | Per-controller write data |
| cpu_done | output | N_CACHE | One-cycle completion pulse |
| cpu_rdata | output | N_CACHE*DATA_W | Read result, valid with done |
| bus_valid | output | 1 | A transaction owns the bus this cycle |
| bus_cmd | output | 2 | 1 read, 2 read-exclusive, 3 upgrade, 0 idle |
| bus_addr | output | ADDR_W | Address of the current transaction |
| bus_src | output | ID_W | Index of the granted controller |

## Verification
The bus outputs are combinational from the arbiter, so the bench samples them one nanosecond after the falling edge in the same cycle the request is presented. The done pulse and read data come from registers, so they are sampled at the next falling edge. With a single requester, both a hit and a bus miss are therefore due exactly one cycle after the request. When several controllers request together, each grant is checked in its own cycle and its done pulse one cycle later. A reference model of line states and a golden memory image give the expected bus command and read value for every access.

// File: rtl/msi_pkg.sv
package msi_pkg;
   typedef enum logic [1:0] {
      LS_INV = 2'd0,
      LS_SHR = 2'd1,
      LS_MOD = 2'd2
   } line_st_e;

   typedef enum logic [1:0] {
      BC_IDLE = 2'd0,
      BC_RD   = 2'd1,
      BC_RDX  = 2'd2,
      BC_UPG  = 2'd3
   } bus_cmd_e;
endpackage

// File: rtl/msi_rr_arb.sv
module msi_rr_arb #(
   parameter int N    = 4,
   parameter int ID_W = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [N-1:0]  req,
   output logic [N-1:0]  grant,
   output logic [ID_W-1:0] gnt_id
);
   logic [ID_W-1:0] last_q;

   always_comb begin
      grant  = '0;
      gnt_id = '0;
      for (int k = 1; k <= N; k++) begin
         automatic int c = (int'(last_q) + k) % N;
         if (req[c] && (grant == '0)) begin
            grant[c] = 1'b1;
            gnt_id   = ID_W'(c);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       last_q <= ID_W'(N - 1);
      else if (|grant)  last_q <= gnt_id;
   end
endmodule

// File: rtl/msi_mem.sv
module msi_mem #(
   parameter int ADDR_W = 5,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   input  logic              wa_en,
   input  logic [ADDR_W-1:0] wa_addr,
   input  logic [DATA_W-1:0] wa_data,
   input  logic              wb_en,
   input  logic [ADDR_W-1:0] wb_addr,
   input  logic [DATA_W-1:0] wb_data
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem_q [DEPTH];

   assign rd_data = mem_q[rd_addr];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      end else begin
         if (wa_en) mem_q[wa_addr] <= wa_data;
         if (wb_en) mem_q[wb_addr] <= wb_data;
      end
   end
endmodule

// File: rtl/msi_cache_ctl.sv
module msi_cache_ctl
   import msi_pkg::*;
#(
   parameter int ADDR_W = 5,
   parameter int DATA_W = 8,
   parameter int IDX_W  = 2,
   parameter int SETS   = 1 << IDX_W,
   parameter int TAG_W  = ADDR_W - IDX_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic              cpu_done,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic              bus_req,
   output bus_cmd_e          bus_cmd_req,
   input  logic              grant,
   input  logic              bus_valid,
   input  bus_cmd_e          bus_cmd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] fill_data,
   output logic              snp_dirty,
   output logic [DATA_W-1:0] snp_data,
   output logic              victim_wb,
   output logic [ADDR_W-1:0] victim_addr,
   output logic [DATA_W-1:0] victim_data,
   output logic [SETS*2-1:0]     obs_state,
   output logic [SETS*TAG_W-1:0] obs_tag
);
   line_st_e          st_q  [SETS];
   logic [TAG_W-1:0]  tag_q [SETS];
   logic [DATA_W-1:0] dat_q [SETS];
   logic              done_q;
   logic [DATA_W-1:0] rdata_q;

   logic [IDX_W-1:0] r_idx, s_idx;
   logic [TAG_W-1:0] r_tag, s_tag;
   logic hit, local_ok, active, local_go, s_hit;

   assign r_idx = cpu_addr[IDX_W-1:0];
   assign r_tag = cpu_addr[ADDR_W-1:IDX_W];
   assign s_idx = bus_addr[IDX_W-1:0];
   assign s_tag = bus_addr[ADDR_W-1:IDX_W];

   assign hit      = (st_q[r_idx] != LS_INV) && (tag_q[r_idx] == r_tag);
   assign local_ok = hit && (!cpu_we || (st_q[r_idx] == LS_MOD));
   assign active   = cpu_req && !done_q;
   assign bus_req  = active && !local_ok;
   assign bus_cmd_req = !cpu_we ? BC_RD : (hit ? BC_UPG : BC_RDX);
   // a local hit must not race a snoop update of the same array
   assign local_go = active && local_ok && !bus_valid;

   assign victim_wb   = grant && !hit && (st_q[r_idx] == LS_MOD);
   assign victim_addr = {tag_q[r_idx], r_idx};
   assign victim_data = dat_q[r_idx];

   assign s_hit     = bus_valid && !grant && (st_q[s_idx] != LS_INV) && (tag_q[s_idx] == s_tag);
   assign snp_dirty = s_hit && (st_q[s_idx] == LS_MOD);
   assign snp_data  = dat_q[s_idx];

   assign cpu_done  = done_q;
   assign cpu_rdata = rdata_q;

   always_comb begin
      for (int s = 0; s < SETS; s++) begin
         obs_state[s*2 +: 2]        = st_q[s];
         obs_tag[s*TAG_W +: TAG_W]  = tag_q[s];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++) begin
            st_q[s]  <= LS_INV;
            tag_q[s] <= '0;
            dat_q[s] <= '0;
         end
         done_q  <= 1'b0;
         rdata_q <= '0;
      end else begin
         done_q <= 1'b0;
         if (s_hit) st_q[s_idx] <= (bus_cmd == BC_RD) ? LS_SHR : LS_INV;
         if (grant) begin
            st_q[r_idx]  <= cpu_we ? LS_MOD : LS_SHR;
            tag_q[r_idx] <= r_tag;
            dat_q[r_idx] <= cpu_we ? cpu_wdata : fill_data;
            rdata_q      <= cpu_we ? cpu_wdata : fill_data;
            done_q       <= 1'b1;
         end else if (local_go) begin
            if (cpu_we) dat_q[r_idx] <= cpu_wdata;
            rdata_q <= cpu_we ? cpu_wdata : dat_q[r_idx];
            done_q  <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/snoop_msi_cluster.sv
module snoop_msi_cluster
   import msi_pkg::*;
#(
   parameter int N_CACHE = 4,
   parameter int ADDR_W  = 5,
   parameter int DATA_W  = 8,
   parameter int IDX_W   = 2,
   parameter int ID_W    = $clog2(N_CACHE)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [N_CACHE-1:0]          cpu_req,
   input  logic [N_CACHE-1:0]          cpu_we,
   input  logic [N_CACHE*ADDR_W-1:0]   cpu_addr,
   input  logic [N_CACHE*DATA_W-1:0]   cpu_wdata,
   output logic [N_CACHE-1:0]          cpu_done,
   output logic [N_CACHE*DATA_W-1:0]   cpu_rdata,
   output logic                        bus_valid,
   output logic [1:0]                  bus_cmd,
   output logic [ADDR_W-1:0]           bus_addr,
   output logic [ID_W-1:0]             bus_src
);
   localparam int SETS  = 1 << IDX_W;
   localparam int TAG_W = ADDR_W - IDX_W;

   if (N_CACHE < 2) begin : g_bad_n
      $error("N_CACHE must be at least 2");
   end
   if (IDX_W < 1 || IDX_W >= ADDR_W) begin : g_bad_idx
      $error("IDX_W must lie between 1 and ADDR_W-1");
   end
   if (ADDR_W > 12) begin : g_bad_aw
      $error("ADDR_W too large for the flat memory model");
   end
   if (ID_W != $clog2(N_CACHE)) begin : g_bad_id
      $error("ID_W must equal clog2(N_CACHE)");
   end

   logic [N_CACHE-1:0] breq, grant, sdirty, vwb;
   bus_cmd_e           creq  [N_CACHE];
   logic [DATA_W-1:0]  sdata [N_CACHE];
   logic [DATA_W-1:0]  vdata [N_CACHE];
   logic [ADDR_W-1:0]  vaddr [N_CACHE];
   logic [N_CACHE*SETS*2-1:0]     obs_st_flat;
   logic [N_CACHE*SETS*TAG_W-1:0] obs_tag_flat;

   bus_cmd_e          bus_cmd_w;
   logic              any_dirty, v_we;
   logic [DATA_W-1:0] own_data, v_d, mem_rd, fill_data;
   logic [ADDR_W-1:0] v_a;

   msi_rr_arb #(.N(N_CACHE), .ID_W(ID_W)) u_arb (
      .clk(clk), .rst_n(rst_n), .req(breq), .grant(grant), .gnt_id(bus_src)
   );

   assign bus_valid = |grant;
   assign bus_cmd   = bus_cmd_w;

   always_comb begin
      bus_cmd_w = BC_IDLE;
      bus_addr  = '0;
      any_dirty = 1'b0;
      own_data  = '0;
      v_we      = 1'b0;
      v_a       = '0;
      v_d       = '0;
      for (int i = 0; i < N_CACHE; i++) begin
         if (grant[i]) begin
            bus_cmd_w = creq[i];
            bus_addr  = cpu_addr[i*ADDR_W +: ADDR_W];
         end
         if (sdirty[i]) begin
            any_dirty = 1'b1;
            own_data  = sdata[i];
         end
         if (vwb[i]) begin
            v_we = 1'b1;
            v_a  = vaddr[i];
            v_d  = vdata[i];
         end
      end
   end

   assign fill_data = any_dirty ? own_data : mem_rd;

   for (genvar i = 0; i < N_CACHE; i++) begin : g_ctl
      msi_cache_ctl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_ctl (
         .clk        (clk),
         .rst_n      (rst_n),
         .cpu_req    (cpu_req[i]),
         .cpu_we     (cpu_we[i]),
         .cpu_addr   (cpu_addr[i*ADDR_W +: ADDR_W]),
         .cpu_wdata  (cpu_wdata[i*DATA_W +: DATA_W]),
         .cpu_done   (cpu_done[i]),
         .cpu_rdata  (cpu_rdata[i*DATA_W +: DATA_W]),
         .bus_req    (breq[i]),
         .bus_cmd_req(creq[i]),
         .grant      (grant[i]),
         .bus_valid  (bus_valid),
         .bus_cmd    (bus_cmd_w),
         .bus_addr   (bus_addr),
         .fill_data  (fill_data),
         .snp_dirty  (sdirty[i]),
         .snp_data   (sdata[i]),
         .victim_wb  (vwb[i]),
         .victim_addr(vaddr[i]),
         .victim_data(vdata[i]),
         .obs_state  (obs_st_flat[i*SETS*2 +: SETS*2]),
         .obs_tag    (obs_tag_flat[i*SETS*TAG_W +: SETS*TAG_W])
      );
   end

   msi_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
      .clk(clk), .rst_n(rst_n),
      .rd_addr(bus_addr), .rd_data(mem_rd),
      .wa_en(v_we), .wa_addr(v_a), .wa_data(v_d),
      .wb_en(any_dirty), .wb_addr(bus_addr), .wb_data(own_data)
   );
endmodule

// File: rtl/msi_coh_checker.sv
module msi_coh_checker #(
   parameter int N_CACHE = 4,
   parameter int ADDR_W  = 5,
   parameter int IDX_W   = 2,
   parameter int ID_W    = 2,
   parameter int SETS    = 1 << IDX_W,
   parameter int TAG_W   = ADDR_W - IDX_W
) (
   input logic                            clk,
   input logic                            rst_n,
   input logic [N_CACHE-1:0]              cpu_req,
   input logic [N_CACHE-1:0]              cpu_done,
   input logic [N_CACHE-1:0]              grant,
   input logic                            bus_valid,
   input logic [ID_W-1:0]                 bus_src,
   input logic [N_CACHE*SETS*2-1:0]       obs_st_flat,
   input logic [N_CACHE*SETS*TAG_W-1:0]   obs_tag_flat
);
   logic viol;

   always_comb begin
      viol = 1'b0;
      for (int s = 0; s < SETS; s++)
         for (int i = 0; i < N_CACHE; i++)
            for (int j = 0; j < N_CACHE; j++)
               if (i != j &&
                   obs_st_flat[(i*SETS+s)*2 +: 2] == 2'd2 &&
                   obs_st_flat[(j*SETS+s)*2 +: 2] != 2'd0 &&
                   obs_tag_flat[(i*SETS+s)*TAG_W +: TAG_W] == obs_tag_flat[(j*SETS+s)*TAG_W +: TAG_W])
                  viol = 1'b1;
   end

   AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant)); // R7

   AST_BUS_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      bus_valid |-> cpu_req[bus_src]); // R2

   AST_DONE_AFTER_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      (|grant) |=> ((cpu_done & $past(grant)) == $past(grant))); // R10

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      (|cpu_done) |=> ((cpu_done & $past(cpu_done)) == '0)); // R10

   AST_SINGLE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
      !viol); // R9
endmodule

bind snoop_msi_cluster msi_coh_checker #(
   .N_CACHE(N_CACHE), .ADDR_W(ADDR_W), .IDX_W(IDX_W), .ID_W(ID_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_done(cpu_done),
   .grant(grant), .bus_valid(bus_valid), .bus_src(bus_src),
   .obs_st_flat(obs_st_flat), .obs_tag_flat(obs_tag_flat)
);

// File: tb/sim_snoop_msi_cluster.sv
`timescale 1ns/1ps
module sim_snoop_msi_cluster;
   localparam int N  = 4;
   localparam int AW = 5;
   localparam int DW = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [N-1:0]    cpu_req = '0;
   logic [N-1:0]    cpu_we = '0;
   logic [N*AW-1:0] cpu_addr = '0;
   logic [N*DW-1:0] cpu_wdata = '0;
   logic [N-1:0]    cpu_done;
   logic [N*DW-1:0] cpu_rdata;
   logic            bus_valid;
   logic [1:0]      bus_cmd;
   logic [AW-1:0]   bus_addr;
   logic [1:0]      bus_src;

   int n_chk = 0;
   int n_fail = 0;
   int lastsrc = 3;
   int mst  [N][4];
   int mtag [N][4];
   logic [DW-1:0] gold [32];

   always #4 clk = ~clk;

   snoop_msi_cluster u0 (
      .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
      .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_done(cpu_done),
      .cpu_rdata(cpu_rdata), .bus_valid(bus_valid), .bus_cmd(bus_cmd),
      .bus_addr(bus_addr), .bus_src(bus_src)
   );

   task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
      end
   endtask

   function automatic bit other_mod(input int id, input int a);
      bit r = 0;
      for (int j = 0; j < N; j++)
         if (j != id && mst[j][a%4] == 2 && mtag[j][a%4] == a/4) r = 1;
      return r;
   endfunction

   function automatic int exp_cmd(input int id, input bit we, input int a);
      bit h = (mst[id][a%4] != 0) && (mtag[id][a%4] == a/4);
      if (!we) return h ? 0 : 1;
      if (h && mst[id][a%4] == 2) return 0;
      return h ? 3 : 2;
   endfunction

   task automatic model_upd(input int id, input bit we, input int a, input logic [DW-1:0] wd);
      int c = exp_cmd(id, we, a);
      if (c != 0)
         for (int j = 0; j < N; j++)
            if (j != id && mst[j][a%4] != 0 && mtag[j][a%4] == a/4)
               mst[j][a%4] = we ? 0 : 1;
      if (we) begin
         mst[id][a%4] = 2; mtag[id][a%4] = a/4; gold[a] = wd;
      end else if (c != 0) begin
         mst[id][a%4] = 1; mtag[id][a%4] = a/4;
      end
   endtask

   task automatic access(input int id, input bit we, input int a, input logic [DW-1:0] wd, input string dtag);
      int cyc = 0; bit seen = 0; int scmd = 0;
      int ecmd = exp_cmd(id, we, a);
      bit om = other_mod(id, a);
      string crq;
      @(negedge clk);
      cpu_req[id] = 1'b1; cpu_we[id] = we;
      cpu_addr[id*AW +: AW] = AW'(a); cpu_wdata[id*DW +: DW] = wd;
      forever begin
         #1;
         if (bus_valid && int'(bus_src) == id) begin seen = 1; scmd = int'(bus_cmd); lastsrc = id; end
         @(negedge clk);
         cyc++;
         if (cpu_done[id] || cyc > 20) break;
      end
      cpu_req[id] = 1'b0;
      chk(cyc == 1, "R10", "done latency", cyc, 1);
      if (we && ecmd != 0 && om) crq = "R9";
      else if (!we) crq = "R2";
      else if (ecmd == 0) crq = "R4";
      else crq = "R3";
      if (ecmd == 0) chk(!seen, crq, "unexpected bus cmd", scmd, 0);
      else chk(seen && scmd == ecmd, crq, "bus cmd", seen ? scmd : 0, ecmd);
      if (!we)
         chk(cpu_rdata[id*DW +: DW] == gold[a], dtag != "" ? dtag : (om ? "R5" : "R8"),
             "read data", int'(cpu_rdata[id*DW +: DW]), int'(gold[a]));
      model_upd(id, we, a, wd);
   endtask

   task automatic rr_round(input logic [N-1:0] mask, input bit we, input int base);
      logic [N-1:0] pend = mask;
      int guard = 0;
      @(negedge clk);
      for (int i = 0; i < N; i++)
         if (mask[i]) begin
            cpu_req[i] = 1'b1; cpu_we[i] = we;
            cpu_addr[i*AW +: AW] = AW'(base + i);
            cpu_wdata[i*DW +: DW] = DW'(8'hA0 + base + i);
         end
      while (pend != 0 && guard < 40) begin
         int nx = -1; int a; int ecmd; bit om;
         guard++;
         for (int k = 1; k <= N; k++)
            if (nx < 0 && pend[(lastsrc + k) % N]) nx = (lastsrc + k) % N;
         a = base + nx; ecmd = exp_cmd(nx, we, a); om = other_mod(nx, a);
         #1;
         chk(bus_valid && int'(bus_src) == nx, "R7", "grant order", bus_valid ? int'(bus_src) : -1, nx);
         chk(int'(bus_cmd) == ecmd, we ? "R3" : "R2", "rr bus cmd", int'(bus_cmd), ecmd);
         @(negedge clk);
         chk(cpu_done == N'(1 << nx), "R10", "done vector", int'(cpu_done), 1 << nx);
         if (!we)
            chk(cpu_rdata[nx*DW +: DW] == gold[a], om ? "R5" : "R8", "rr read data",
                int'(cpu_rdata[nx*DW +: DW]), int'(gold[a]));
         model_upd(nx, we, a, DW'(8'hA0 + base + nx));
         pend[nx] = 1'b0; cpu_req[nx] = 1'b0; lastsrc = nx;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [15:0] lf = 16'hACE1;
      for (int i = 0; i < N; i++) for (int s = 0; s < 4; s++) begin mst[i][s] = 0; mtag[i][s] = 0; end
      for (int a = 0; a < 32; a++) gold[a] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(cpu_done == '0, "R1", "done after reset", int'(cpu_done), 0);
      chk(!bus_valid, "R1", "bus after reset", int'(bus_valid), 0);
      access(0, 0, 5, 8'h00, "R1");
      // R7: partial then full contention
      rr_round(4'b0101, 1'b1, 0);
      rr_round(4'b1111, 1'b0, 8);
      // R6: dirty victims of round two must be in memory
      access(1, 0, 0, 8'h00, "R6");
      access(3, 0, 2, 8'h00, "R6");
      // R2 sharing, R3 upgrade/invalidate, R5 owner supply, R4 silent write
      access(2, 0, 0, 8'h00, "");
      access(1, 0, 0, 8'h00, "");
      access(2, 0, 0, 8'h00, "");
      access(1, 1, 0, 8'h55, "");
      access(2, 0, 0, 8'h00, "R5");
      access(1, 1, 0, 8'h66, "");
      access(1, 1, 0, 8'h77, "");
      access(3, 1, 0, 8'h88, "");
      access(1, 0, 0, 8'h00, "R5");
      // sweep
      for (int it = 0; it < 800; it++) begin
         lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
         access(int'(lf[1:0]), lf[2], int'(lf[8:4]), lf[15:8], "");
      end
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule